// File: doc/BRIEF.md
# Multi-cycle processor datapath

This block is the datapath of a 32-bit multi-cycle processor. It runs a small load/store instruction subset: word load, word store, register-register arithmetic, branch on equal, and jump. A single ALU and a single memory are shared across the steps of each instruction. The memory holds both instructions and data. Holding registers pass values from one step to the next: the program counter, the instruction register, the memory data register, the two operand registers, and the ALU output register.

The datapath makes no decisions of its own. Every multiplexer select and every write enable is an input, driven by an external sequencer that is not part of this block. In return the datapath reports four things to that sequencer: the opcode and function fields of the held instruction, a zero flag from the ALU, and a signed-overflow flag. It also exposes the program counter and the live ALU result, so the state of an instruction can be seen from outside. The memory is an internal word array that a testbench preloads. Reads from it are combinational and writes happen on the clock edge.

Top module: `mc_datapath`

## Requirements
- R1: While the asynchronous active-low reset is held, the program counter, the instruction register and the holding registers are zero. After reset, `pc_out`, `opcode` and `funct` read 0.
- R2: The memory address is the program counter when `sel_addr`=0 and the ALU output register when `sel_addr`=1. Memory reads are combinational, and bits [7:2] of the address index a word. The instruction register loads the read word only on an edge where `ir_we`=1; otherwise it holds.
- R3: ALU operand A is the program counter when `sel_opa`=0 and the A register when `sel_opa`=1.
- R4: ALU operand B depends on `sel_opb`: 0 selects the B register, 1 the constant 4, 2 the sign-extended instruction bits [15:0], and 3 that sign-extended value shifted left by two.
- R5: `alu_mode` 0 adds, 1 subtracts (A minus B), and 3 also adds. When `alu_mode` is 2, the operation comes from instruction bits [5:0].
- R6: The function codes are 0x20 add, 0x22 subtract, 0x24 bitwise AND, 0x25 bitwise OR and 0x2A signed set-less-than, which gives 1 or 0. Any other code adds.
- R7: `alu_ovf` is 1 exactly when the current ALU operation is an add or a subtract and its signed 32-bit result overflows.
- R8: `alu_zero` is 1 exactly when the live ALU result is zero.
- R9: The next program counter depends on `sel_pc`: 0 selects the live ALU result, 1 the ALU output register, 2 the jump target {pc[31:28], instruction[25:0], 2'b00}, and 3 the fixed vector 0x80000180.
- R10: The program counter loads on an edge where `pc_we`=1, or where `pc_we_cond`=1 and `alu_zero`=1. Otherwise it holds.
- R11: The register file write address is instruction bits [20:16] when `sel_dst`=0 and bits [15:11] when `sel_dst`=1. The write data is the ALU output register when `sel_wb`=0 and the memory data register when `sel_wb`=1. The write happens on the edge where `rf_we`=1. Register 0 always reads zero.
- R12: On an edge where `mem_we`=1, the word at the selected address takes the value of the B register.
- R13: On every edge, A loads register[instruction[25:21]], B loads register[instruction[20:16]], the ALU output register loads the live ALU result, and the memory data register loads the memory read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_addr | input | 1 | Memory address select |
| sel_opa | input | 1 | ALU operand A select |
| sel_opb | input | 2 | ALU operand B select |
| alu_mode | input | 2 | ALU operation class |
| sel_pc | input | 2 | Next program counter select |
| pc_we | input | 1 | Unconditional program counter write |
| pc_we_cond | input | 1 | Program counter write when ALU result is zero |
| ir_we | input | 1 | Instruction register load |
| mem_we | input | 1 | Memory write |
| rf_we | input | 1 | Register file write |
| sel_dst | input | 1 | Register write address select |
| sel_wb | input | 1 | Register write data select |
| opcode | output | 6 | Instruction bits [31:26] |
| funct | output | 6 | Instruction bits [5:0] |
| alu_zero | output | 1 | Live ALU result is zero |
| alu_ovf | output | 1 | Signed overflow of add or subtract |
| pc_out | output | 32 | Program counter |
| alu_res | output | 32 | Live ALU result |

## Verification
The bench acts as the sequencer and drives a short program that uses every instruction class. A behavioural model predicts the outputs on every cycle. Loads of a large positive word, a small one and a negative one give operands that separate signed set-less-than from unsigned compare, and an add of the maximum positive value and one shows whether overflow is detected. Two branches are run: one with equal operands, which must redirect the program counter, and one with unequal operands, which must leave the increment in place. A store followed by a load of the same word shows that the write reached memory. An idle cycle shows that the program counter and the instruction register hold. The exception-vector select is then taken, and the instruction found at the vector is fetched.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int XLEN = 32;

  localparam logic [1:0] MODE_ADD   = 2'd0;
  localparam logic [1:0] MODE_SUB   = 2'd1;
  localparam logic [1:0] MODE_FIELD = 2'd2;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  localparam logic [XLEN-1:0] EXC_VECTOR = 32'h8000_0180;

  typedef enum logic [2:0] {
    OP_ADD,
    OP_SUB,
    OP_AND,
    OP_OR,
    OP_SLT
  } alu_op_e;
endpackage

// File: rtl/mcd_alu.sv
module mcd_alu
  import mcd_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [1:0]   mode,
  input  logic [5:0]   fn,
  output logic [W-1:0] y,
  output logic         zero,
  output logic         ovf
);
  alu_op_e      op;
  logic [W-1:0] sum, diff;
  logic         lt;

  // operation decode: class first, then the function field
  always_comb begin
    op = OP_ADD;
    case (mode)
      MODE_SUB:   op = OP_SUB;
      MODE_FIELD: begin
        case (fn)
          FN_SUB:  op = OP_SUB;
          FN_AND:  op = OP_AND;
          FN_OR:   op = OP_OR;
          FN_SLT:  op = OP_SLT;
          default: op = OP_ADD;
        endcase
      end
      default:    op = OP_ADD;
    endcase
  end

  assign sum  = opa + opb;
  assign diff = opa - opb;
  assign lt   = $signed(opa) < $signed(opb);

  always_comb begin
    case (op)
      OP_SUB:  y = diff;
      OP_AND:  y = opa & opb;
      OP_OR:   y = opa | opb;
      OP_SLT:  y = {{(W-1){1'b0}}, lt};
      default: y = sum;
    endcase
  end

  always_comb begin
    case (op)
      OP_ADD:  ovf = (opa[W-1] == opb[W-1]) && (sum[W-1] != opa[W-1]);
      OP_SUB:  ovf = (opa[W-1] != opb[W-1]) && (diff[W-1] != opa[W-1]);
      default: ovf = 1'b0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    logic hit;
    assign hit = we && (wa == AW'(g)) && (g != 0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[g] <= '0;
      else if (hit) regs[g] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mcd_mem.sv
module mcd_mem #(
  parameter int W     = 32,
  parameter int WORDS = 64,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic         clk,
  input  logic [W-1:0] addr,
  output logic [W-1:0] rdata,
  input  logic         we,
  input  logic [W-1:0] wdata
);
  logic [W-1:0]  mem_q [WORDS];
  logic [IW-1:0] idx;
  logic          unused_addr_bits;

  assign idx              = addr[IW+1:2];
  assign unused_addr_bits = ^{addr[W-1:IW+2], addr[1:0]};
  assign rdata            = mem_q[idx];

  always_ff @(posedge clk) begin
    if (we) mem_q[idx] <= wdata;
  end
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mcd_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  parameter int RF_DEPTH  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_addr,
  input  logic            sel_opa,
  input  logic [1:0]      sel_opb,
  input  logic [1:0]      alu_mode,
  input  logic [1:0]      sel_pc,
  input  logic            pc_we,
  input  logic            pc_we_cond,
  input  logic            ir_we,
  input  logic            mem_we,
  input  logic            rf_we,
  input  logic            sel_dst,
  input  logic            sel_wb,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic            alu_zero,
  output logic            alu_ovf,
  output logic [XLEN-1:0] pc_out,
  output logic [XLEN-1:0] alu_res
);
  localparam int RAW = $clog2(RF_DEPTH);

  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aout_q;
  logic [XLEN-1:0] pc_d, ir_d;
  logic [XLEN-1:0] mem_addr, mem_rdata, rf_rd1, rf_rd2;
  logic [XLEN-1:0] imm_sx, imm_sh, opa, opb, jump_tgt, pc_src, rf_wd;
  logic [RAW-1:0]  rf_wa;
  logic            pc_load;

  // shared memory: fetch or data access
  assign mem_addr = sel_addr ? aout_q : pc_q;

  mcd_mem #(.W(XLEN), .WORDS(MEM_WORDS)) u_mem (
    .clk   (clk),
    .addr  (mem_addr),
    .rdata (mem_rdata),
    .we    (mem_we),
    .wdata (b_q)
  );

  // register file
  assign rf_wa = sel_dst ? RAW'(ir_q[15:11]) : RAW'(ir_q[20:16]);
  assign rf_wd = sel_wb ? mdr_q : aout_q;

  mcd_regfile #(.W(XLEN), .DEPTH(RF_DEPTH)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra1   (RAW'(ir_q[25:21])),
    .ra2   (RAW'(ir_q[20:16])),
    .rd1   (rf_rd1),
    .rd2   (rf_rd2),
    .we    (rf_we),
    .wa    (rf_wa),
    .wd    (rf_wd)
  );

  // operand selection
  assign imm_sx = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign imm_sh = {imm_sx[XLEN-3:0], 2'b00};
  assign opa    = sel_opa ? a_q : pc_q;

  always_comb begin
    case (sel_opb)
      2'd0:    opb = b_q;
      2'd1:    opb = XLEN'(4);
      2'd2:    opb = imm_sx;
      default: opb = imm_sh;
    endcase
  end

  mcd_alu #(.W(XLEN)) u_alu (
    .opa  (opa),
    .opb  (opb),
    .mode (alu_mode),
    .fn   (ir_q[5:0]),
    .y    (alu_res),
    .zero (alu_zero),
    .ovf  (alu_ovf)
  );

  // next program counter
  assign jump_tgt = {pc_q[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};

  always_comb begin
    case (sel_pc)
      2'd0:    pc_src = alu_res;
      2'd1:    pc_src = aout_q;
      2'd2:    pc_src = jump_tgt;
      default: pc_src = EXC_VECTOR;
    endcase
  end

  assign pc_load = pc_we | (pc_we_cond & alu_zero);

  always_comb begin
    pc_d = pc_q;
    ir_d = ir_q;
    if (pc_load) pc_d = pc_src;
    if (ir_we)   ir_d = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      ir_q   <= '0;
      mdr_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      aout_q <= '0;
    end else begin
      pc_q   <= pc_d;
      ir_q   <= ir_d;
      mdr_q  <= mem_rdata;
      a_q    <= rf_rd1;
      b_q    <= rf_rd2;
      aout_q <= alu_res;
    end
  end

  assign opcode = ir_q[31:26];
  assign funct  = ir_q[5:0];
  assign pc_out = pc_q;

  // R10: no write request keeps the program counter
  p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_we && !pc_we_cond) |=> $stable(pc_q));

  // R10: conditional write with nonzero result keeps the program counter
  p_pc_cond_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we_cond && !pc_we && !alu_zero) |=> $stable(pc_q));

  // R2: instruction register holds without its enable
  p_ir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_we |=> $stable(ir_q));

  // R11: register 0 reads as zero into A
  p_r0_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_q[25:21] == 5'd0) |=> (a_q == '0));

  // R9: jump stays in the current 256 MB region, word aligned
  p_jump_region_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && sel_pc == 2'd2) |=>
      (pc_q[1:0] == 2'b00) && (pc_q[XLEN-1:XLEN-4] == $past(pc_q[XLEN-1:XLEN-4])));

  // R9: vector select lands on the fixed handler address
  p_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && sel_pc == 2'd3) |=> (pc_q == EXC_VECTOR));
endmodule

// File: tb/test_mc_datapath.sv
`timescale 1ns/1ps
module test_mc_datapath;
  localparam int WORDS = 64;
  localparam int WD_CYCLES = 200000;

  logic        clk, rst_n;
  logic        sel_addr, sel_opa, pc_we, pc_we_cond, ir_we, mem_we, rf_we, sel_dst, sel_wb;
  logic [1:0]  sel_opb, alu_mode, sel_pc;
  logic [5:0]  opcode, funct;
  logic        alu_zero, alu_ovf;
  logic [31:0] pc_out, alu_res;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  mc_datapath i_mc_datapath (
    .clk(clk), .rst_n(rst_n), .sel_addr(sel_addr), .sel_opa(sel_opa),
    .sel_opb(sel_opb), .alu_mode(alu_mode), .sel_pc(sel_pc), .pc_we(pc_we),
    .pc_we_cond(pc_we_cond), .ir_we(ir_we), .mem_we(mem_we), .rf_we(rf_we),
    .sel_dst(sel_dst), .sel_wb(sel_wb), .opcode(opcode), .funct(funct),
    .alu_zero(alu_zero), .alu_ovf(alu_ovf), .pc_out(pc_out), .alu_res(alu_res)
  );

  initial begin
    clk = 0;
    forever #4 clk = ~clk;
  end

  // behavioural model state
  logic [31:0] m_mem [WORDS];
  logic [31:0] m_rf  [32];
  logic [31:0] m_pc, m_ir, m_mdr, m_a, m_b, m_aout;

  function automatic logic [31:0] rtype(int rs, int rt, int rd, int fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h0, 6'(fn)};
  endfunction
  function automatic logic [31:0] itype(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic ref_alu(input logic [1:0] mode, input logic [5:0] fn,
                         input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] y, output logic v);
    longint sa, sb, r;
    int kind; // 0 add 1 sub 2 and 3 or 4 slt
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    kind = 0;
    if (mode == 2'd1) kind = 1;
    else if (mode == 2'd2) begin
      if (fn == 6'h22) kind = 1;
      else if (fn == 6'h24) kind = 2;
      else if (fn == 6'h25) kind = 3;
      else if (fn == 6'h2A) kind = 4;
    end
    v = 0;
    case (kind)
      1: begin r = sa - sb; y = r[31:0]; v = (r > 64'sd2147483647) || (r < -64'sd2147483648); end
      2: y = a & b;
      3: y = a | b;
      4: y = (sa < sb) ? 32'd1 : 32'd0;
      default: begin r = sa + sb; y = r[31:0]; v = (r > 64'sd2147483647) || (r < -64'sd2147483648); end
    endcase
  endtask

  task automatic clear_ctl;
    sel_addr = 0; sel_opa = 0; sel_opb = 0; alu_mode = 0; sel_pc = 0;
    pc_we = 0; pc_we_cond = 0; ir_we = 0; mem_we = 0; rf_we = 0; sel_dst = 0; sel_wb = 0;
  endtask

  // one clock: compare outputs against the model, then advance the model
  task automatic cyc(string tag);
    logic [31:0] addr, rd, a, b, y, imm, nxt;
    logic v, z;
    #1;
    addr = sel_addr ? m_aout : m_pc;
    rd   = m_mem[addr[7:2]];
    imm  = {{16{m_ir[15]}}, m_ir[15:0]};
    a    = sel_opa ? m_a : m_pc;
    case (sel_opb)
      2'd0: b = m_b;
      2'd1: b = 32'd4;
      2'd2: b = imm;
      default: b = imm << 2;
    endcase
    ref_alu(alu_mode, m_ir[5:0], a, b, y, v);
    z = (y == 0);
    check(tag, "alu_res", alu_res, y);
    check(tag, "alu_zero", 32'(alu_zero), 32'(z));
    check(tag, "alu_ovf", 32'(alu_ovf), 32'(v));
    check(tag, "pc_out", pc_out, m_pc);
    check(tag, "opcode", 32'(opcode), 32'(m_ir[31:26]));
    check(tag, "funct", 32'(funct), 32'(m_ir[5:0]));
    case (sel_pc)
      2'd0: nxt = y;
      2'd1: nxt = m_aout;
      2'd2: nxt = {m_pc[31:28], m_ir[25:0], 2'b00};
      default: nxt = 32'h8000_0180;
    endcase
    if (mem_we) m_mem[addr[7:2]] = m_b;
    if (rf_we) begin
      int wa;
      wa = sel_dst ? int'(m_ir[15:11]) : int'(m_ir[20:16]);
      if (wa != 0) m_rf[wa] = sel_wb ? m_mdr : m_aout;
    end
    m_a    = m_rf[m_ir[25:21]];
    m_b    = m_rf[m_ir[20:16]];
    m_aout = y;
    m_mdr  = rd;
    if (pc_we || (pc_we_cond && z)) m_pc = nxt;
    if (ir_we) m_ir = rd;
    @(negedge clk);
  endtask

  task automatic run_instr;
    logic [5:0] op;
    clear_ctl; ir_we = 1; sel_opb = 2'd1; pc_we = 1;   cyc("R3");
    clear_ctl; sel_opb = 2'd3;                          cyc("R4");
    op = m_ir[31:26];
    case (op)
      6'h23, 6'h2B: begin
        clear_ctl; sel_opa = 1; sel_opb = 2'd2;         cyc("R5");
        if (op == 6'h23) begin
          clear_ctl; sel_addr = 1;                      cyc("R2");
          clear_ctl; sel_wb = 1; rf_we = 1;             cyc("R13");
        end else begin
          clear_ctl; sel_addr = 1; mem_we = 1;          cyc("R12");
        end
      end
      6'h04: begin
        clear_ctl; sel_opa = 1; alu_mode = 2'd1; sel_pc = 2'd1; pc_we_cond = 1;
        cyc((m_a == m_b) ? "R8" : "R10");
      end
      6'h02: begin
        clear_ctl; sel_pc = 2'd2; pc_we = 1;            cyc("R9");
      end
      default: begin
        clear_ctl; sel_opa = 1; alu_mode = 2'd2;
        cyc((m_ir[5:0] == 6'h20) ? "R7" : "R6");
        clear_ctl; sel_dst = 1; rf_we = 1;              cyc("R11");
      end
    endcase
  endtask

  initial begin
    #(8.0 * WD_CYCLES);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    clear_ctl;
    for (int i = 0; i < WORDS; i++) m_mem[i] = 32'h0;
    m_mem[0]  = itype(6'h23, 0, 2, 16'h40);      // load r2
    m_mem[1]  = itype(6'h23, 0, 3, 16'h44);      // load r3
    m_mem[2]  = itype(6'h23, 0, 10, 16'h48);     // load r10
    m_mem[3]  = rtype(2, 3, 4, 6'h20);           // add, overflows
    m_mem[4]  = rtype(3, 2, 5, 6'h22);           // sub
    m_mem[5]  = rtype(2, 10, 6, 6'h24);          // and
    m_mem[6]  = rtype(3, 10, 7, 6'h25);          // or
    m_mem[7]  = rtype(2, 3, 8, 6'h2A);           // slt -> 0
    m_mem[8]  = rtype(10, 3, 9, 6'h2A);          // slt -> 1 (signed)
    m_mem[9]  = itype(6'h2B, 0, 4, 16'h4C);      // store r4
    m_mem[10] = itype(6'h23, 0, 11, 16'h4C);     // reload it
    m_mem[11] = itype(6'h04, 3, 10, 5);          // branch not taken
    m_mem[12] = itype(6'h04, 2, 2, 2);           // branch taken to word 15
    m_mem[15] = {6'h02, 26'd20};                 // jump to word 20
    m_mem[16] = 32'h7FFF_FFFF;
    m_mem[17] = 32'h0000_0001;
    m_mem[18] = 32'hFFFF_FFFE;
    m_mem[20] = rtype(11, 0, 12, 6'h20);         // uses reloaded word
    m_mem[32] = rtype(2, 0, 13, 6'h25);          // at the vector (aliased)
    for (int i = 0; i < WORDS; i++) i_mc_datapath.u_mem.mem_q[i] = m_mem[i];
    for (int i = 0; i < 32; i++) m_rf[i] = 32'h0;
    m_pc = 0; m_ir = 0; m_mdr = 0; m_a = 0; m_b = 0; m_aout = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1", "pc_out in reset", pc_out, 32'h0);
    check("R1", "opcode in reset", 32'(opcode), 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "pc_out after reset", pc_out, 32'h0);
    check("R1", "funct after reset", 32'(funct), 32'h0);

    for (int k = 0; k < 15; k++) run_instr;
    check("R9", "pc after jump and add", pc_out, 32'h54);

    // idle: nothing may move
    clear_ctl; sel_opb = 2'd1; cyc("R10");
    clear_ctl; cyc("R2");
    // vector redirect, then fetch and run the word found there
    clear_ctl; sel_opb = 2'd1; alu_mode = 2'd1; sel_pc = 2'd3; pc_we = 1; cyc("R9");
    check("R9", "pc at vector", pc_out, 32'h8000_0180);
    run_instr;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule